// File: doc/BRIEF.md
# Register-Mapped Network Input Buffers

This block sits between an on-chip network and the operand-fetch stage of a scalar pipeline. It keeps one small FIFO for each network channel end. A network write carries a channel number and a data word, and it is held off by a ready signal while the chosen FIFO is full. The pipeline presents the two source register numbers of the instruction it is about to issue. A number inside the mapped window reads the head word of the matching FIFO in place of the register file value. A number outside the window passes the register file data through unchanged.

Reading a mapped register is destructive: when the instruction issues, the words it used are removed. An instruction whose mapped operand has no data raises a stall, and it issues once the network has delivered the word. A load that sends its response to a channel therefore blocks the pipeline only if a later instruction reaches for that channel before the response has arrived. When both operands name the same channel, the first operand takes the oldest word and the second takes the word behind it.

Top module: `ibuf_rmap_top`

## Requirements
- R1: There are 7 channels (numbered 0 to 6), and each holds up to 4 words in arrival order. A network word is stored in channel `net_chan` in a cycle where `net_valid` and `net_ready` are both high.
- R2: A source register number r with 2 <= r <= 7 selects channel r-2. The operand output for that port shows the oldest word of the channel combinationally.
- R3: An instruction issues in a cycle where `instr_valid` is high and `stall` is low. When it issues, each mapped operand removes the word it received, so the next read of that channel returns the following word.
- R4: `stall` is high when `instr_valid` is high and a mapped operand names a channel with no words. No word is removed while `stall` is high. A word that arrives in the same cycle becomes readable in the next cycle.
- R5: `net_ready` is low when the addressed channel holds 4 words, and also when `net_chan` is 7, which names no channel. A write offered while ready is low leaves every channel unchanged.
- R6: When both operands map to the same channel, operand A receives the oldest word and operand B receives the second oldest, and issuing removes both words. If the channel holds fewer than two words, `stall` is high.
- R7: A register number outside 2..7 (0, 1 and 8..31) drives the matching `rf_*_data` input onto the operand output. Such a number never raises `stall` and never removes a word.
- R8: In a cycle where a channel holding 1 to 3 words both accepts a network write and loses a word to an issuing instruction, both take effect and the channel keeps its order.
- R9: Channel 6 has no register number. It fills from the network, drops `net_ready` when it is full, and holds its words.
- R10: After reset every channel is empty, `net_ready` is high for channels 0..6, and `stall` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| net_valid | input | 1 | A network word is offered |
| net_chan | input | 3 | Target channel of the offered word |
| net_data | input | 32 | Offered network word |
| net_ready | output | 1 | Addressed channel can accept the word |
| instr_valid | input | 1 | An instruction is presenting its operands |
| src_a_idx | input | 5 | Register number of operand A |
| src_b_idx | input | 5 | Register number of operand B |
| rf_a_data | input | 32 | Register file value for operand A |
| rf_b_data | input | 32 | Register file value for operand B |
| opnd_a | output | 32 | Operand A value for the pipeline |
| opnd_b | output | 32 | Operand B value for the pipeline |
| stall | output | 1 | Instruction cannot issue this cycle |

## Verification
The bench builds the block with its default parameters: seven channels, four entries each, and register numbers 2 to 7 mapped to channels 0 to 5. With these values channel 6 can be written but never read, which exercises the full-channel hold-off on a channel that no instruction drains. A depth of four lets directed sequences reach the full and empty limits within a few cycles. A long random phase, biased toward register numbers near the mapped window, mixes paired reads, writes that meet reads in the same cycle, and the out-of-range channel number.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;
   // Width needed to encode n distinct values (minimum one bit)
   function automatic int bits_for(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/ibuf_chan_fifo.sv
module ibuf_chan_fifo
   import ibuf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4,
   localparam int PTR_W = bits_for(DEPTH),
   localparam int CNT_W = bits_for(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic [1:0]        pop_cnt,
   output logic [DATA_W-1:0] head,
   output logic [DATA_W-1:0] second,
   output logic [CNT_W-1:0]  count
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  rd_ptr, wr_ptr;

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + PTR_W'(1);
         rd_ptr <= rd_ptr + PTR_W'(pop_cnt);
         count  <= count + CNT_W'(push) - CNT_W'(pop_cnt);
      end
   end

   assign head   = mem[rd_ptr];
   assign second = mem[rd_ptr + PTR_W'(1)];
endmodule

// File: rtl/ibuf_reg_decode.sv
module ibuf_reg_decode #(
   parameter int REG_W    = 5,
   parameter int CH_W     = 3,
   parameter int MAP_BASE = 2,
   parameter int MAP_CNT  = 6
) (
   input  logic [REG_W-1:0] idx,
   output logic             hit,
   output logic [CH_W-1:0]  ch
);
   localparam logic [REG_W:0] HI = (REG_W+1)'(MAP_BASE + MAP_CNT);
   logic hi_ok;

   assign hi_ok = {1'b0, idx} < HI;
   assign ch    = CH_W'(idx - REG_W'(MAP_BASE));

   generate
      if (MAP_BASE == 0) begin : g_zero_base
         assign hit = hi_ok;
      end else begin : g_offset_base
         localparam logic [REG_W-1:0] LO = REG_W'(MAP_BASE);
         assign hit = hi_ok && (idx >= LO);
      end
   endgenerate
endmodule

// File: rtl/ibuf_rmap_top.sv
module ibuf_rmap_top
   import ibuf_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NUM_CH   = 7,
   parameter int DEPTH    = 4,
   parameter int REG_W    = 5,
   parameter int MAP_BASE = 2,
   parameter int MAP_CNT  = 6,
   localparam int CH_W    = bits_for(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              net_valid,
   input  logic [CH_W-1:0]   net_chan,
   input  logic [DATA_W-1:0] net_data,
   output logic              net_ready,
   input  logic              instr_valid,
   input  logic [REG_W-1:0]  src_a_idx,
   input  logic [REG_W-1:0]  src_b_idx,
   input  logic [DATA_W-1:0] rf_a_data,
   input  logic [DATA_W-1:0] rf_b_data,
   output logic [DATA_W-1:0] opnd_a,
   output logic [DATA_W-1:0] opnd_b,
   output logic              stall
);
   localparam int CNT_W = bits_for(DEPTH + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two and at least 2");
      end
      if (MAP_CNT < 1 || MAP_CNT > NUM_CH) begin : g_bad_map_cnt
         $error("MAP_CNT must lie in 1..NUM_CH");
      end
      if (MAP_BASE < 0 || MAP_BASE + MAP_CNT > (1 << REG_W)) begin : g_bad_window
         $error("mapped register window exceeds the register index range");
      end
   endgenerate

   logic              a_hit, b_hit;
   logic [CH_W-1:0]   a_ch, b_ch;
   logic [CNT_W-1:0]  ch_cnt  [NUM_CH];
   logic [DATA_W-1:0] ch_head [NUM_CH];
   logic [DATA_W-1:0] ch_sec  [NUM_CH];
   logic [1:0]        need    [NUM_CH];
   logic [1:0]        pop_cnt [NUM_CH];
   logic [NUM_CH-1:0] push, short_c;
   logic              pair;

   ibuf_reg_decode #(.REG_W(REG_W), .CH_W(CH_W), .MAP_BASE(MAP_BASE), .MAP_CNT(MAP_CNT))
      dec_a_i (.idx(src_a_idx), .hit(a_hit), .ch(a_ch));
   ibuf_reg_decode #(.REG_W(REG_W), .CH_W(CH_W), .MAP_BASE(MAP_BASE), .MAP_CNT(MAP_CNT))
      dec_b_i (.idx(src_b_idx), .hit(b_hit), .ch(b_ch));

   assign pair = a_hit && b_hit && (a_ch == b_ch);

   // Per-channel demand from the two operand ports and network accept
   always_comb begin
      net_ready = 1'b0;
      for (int c = 0; c < NUM_CH; c++) begin
         need[c]    = {1'b0, instr_valid && a_hit && (a_ch == CH_W'(c))}
                    + {1'b0, instr_valid && b_hit && (b_ch == CH_W'(c))};
         short_c[c] = ch_cnt[c] < CNT_W'(need[c]);
         push[c]    = net_valid && (net_chan == CH_W'(c)) && (ch_cnt[c] != FULL);
         if (net_chan == CH_W'(c)) net_ready = ch_cnt[c] != FULL;
      end
   end

   assign stall = |short_c;

   always_comb begin
      for (int c = 0; c < NUM_CH; c++) begin
         pop_cnt[c] = stall ? 2'd0 : need[c];
      end
   end

   // Operand steering: channel head, or second entry for a same-channel pair
   always_comb begin
      opnd_a = rf_a_data;
      opnd_b = rf_b_data;
      for (int c = 0; c < NUM_CH; c++) begin
         if (a_hit && a_ch == CH_W'(c)) opnd_a = ch_head[c];
         if (b_hit && b_ch == CH_W'(c)) opnd_b = pair ? ch_sec[c] : ch_head[c];
      end
   end

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
         ibuf_chan_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) fifo_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push[g]),
            .push_data (net_data),
            .pop_cnt   (pop_cnt[g]),
            .head      (ch_head[g]),
            .second    (ch_sec[g]),
            .count     (ch_cnt[g])
         );
      end
   endgenerate
endmodule

// File: rtl/ibuf_rmap_chk.sv
module ibuf_rmap_chk #(
   parameter int NUM_CH   = 7,
   parameter int DEPTH    = 4,
   parameter int REG_W    = 5,
   parameter int MAP_BASE = 2,
   parameter int MAP_CNT  = 6,
   parameter int CH_W     = 3,
   parameter int CNT_W    = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             net_valid,
   input logic [CH_W-1:0]  net_chan,
   input logic             net_ready,
   input logic             instr_valid,
   input logic [REG_W-1:0] src_a_idx,
   input logic [REG_W-1:0] src_b_idx,
   input logic             stall,
   input logic [CNT_W-1:0] ch_cnt [NUM_CH]
);
   int  a_num, b_num;
   logic a_in, b_in;

   assign a_num = int'(src_a_idx) - MAP_BASE;
   assign b_num = int'(src_b_idx) - MAP_BASE;
   assign a_in  = (a_num >= 0) && (a_num < MAP_CNT);
   assign b_in  = (b_num >= 0) && (b_num < MAP_CNT);

   // R7
   idle_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!instr_valid || (!a_in && !b_in)) |-> !stall);

   // R5
   bad_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(net_chan) >= NUM_CH) |-> !net_ready);

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         // R1
         no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            int'(ch_cnt[c]) <= DEPTH);
         // R5
         full_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(ch_cnt[c]) == DEPTH && int'(net_chan) == c) |-> !net_ready);
         // R4
         empty_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (instr_valid && a_in && a_num == c && ch_cnt[c] == '0) |-> stall);
         // R6
         pair_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (instr_valid && a_in && b_in && a_num == c && b_num == c
             && int'(ch_cnt[c]) < 2) |-> stall);
         // R4
         stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (stall && !(net_valid && net_ready && int'(net_chan) == c))
            |=> (ch_cnt[c] == $past(ch_cnt[c])));
      end
   endgenerate
endmodule

bind ibuf_rmap_top ibuf_rmap_chk #(
   .NUM_CH(NUM_CH), .DEPTH(DEPTH), .REG_W(REG_W), .MAP_BASE(MAP_BASE),
   .MAP_CNT(MAP_CNT), .CH_W(CH_W), .CNT_W(CNT_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .net_valid(net_valid), .net_chan(net_chan),
   .net_ready(net_ready), .instr_valid(instr_valid), .src_a_idx(src_a_idx),
   .src_b_idx(src_b_idx), .stall(stall), .ch_cnt(ch_cnt)
);

// File: tb/ibuf_rmap_top_tb_top.sv
`timescale 1ns/1ps
module ibuf_rmap_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        net_valid = 1'b0;
   logic [2:0]  net_chan = '0;
   logic [31:0] net_data = '0;
   logic        net_ready;
   logic        instr_valid = 1'b0;
   logic [4:0]  src_a_idx = '0, src_b_idx = '0;
   logic [31:0] rf_a_data = '0, rf_b_data = '0;
   logic [31:0] opnd_a, opnd_b;
   logic        stall;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] mq [7][$];

   always #2.5 clk = ~clk;

   ibuf_rmap_top dut_i (
      .clk(clk), .rst_n(rst_n), .net_valid(net_valid), .net_chan(net_chan),
      .net_data(net_data), .net_ready(net_ready), .instr_valid(instr_valid),
      .src_a_idx(src_a_idx), .src_b_idx(src_b_idx), .rf_a_data(rf_a_data),
      .rf_b_data(rf_b_data), .opnd_a(opnd_a), .opnd_b(opnd_b), .stall(stall)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // One clock cycle: drive, compare against the queue model, then advance it
   task automatic cyc(input string req, input logic nv, input logic [2:0] nc,
                      input logic [31:0] nd, input logic iv,
                      input logic [4:0] a, input logic [4:0] b);
      int need [7];
      logic ha, hb, es, er;
      int ca, cb;
      logic [31:0] ea, eb;
      @(negedge clk);
      net_valid = nv; net_chan = nc; net_data = nd; instr_valid = iv;
      src_a_idx = a; src_b_idx = b;
      rf_a_data = $urandom; rf_b_data = $urandom;
      #1;
      ha = (a >= 2) && (a <= 7); ca = int'(a) - 2;
      hb = (b >= 2) && (b <= 7); cb = int'(b) - 2;
      foreach (need[c]) need[c] = 0;
      if (iv && ha) need[ca]++;
      if (iv && hb) need[cb]++;
      es = 1'b0;
      foreach (need[c]) if (need[c] > mq[c].size()) es = 1'b1;
      er = (nc < 3'd7) && (mq[nc].size() < 4);
      chk(req, "stall", 32'(stall), 32'(es));
      chk(req, "net_ready", 32'(net_ready), 32'(er));
      if (!ha || (iv && !es)) begin
         ea = ha ? mq[ca][0] : rf_a_data;
         chk(req, "opnd_a", opnd_a, ea);
      end
      if (!hb || (iv && !es)) begin
         eb = hb ? ((ha && ca == cb) ? mq[cb][1] : mq[cb][0]) : rf_b_data;
         chk(req, "opnd_b", opnd_b, eb);
      end
      @(posedge clk);
      if (nv && er) mq[nc].push_back(nd);
      if (iv && !es) begin
         if (ha) void'(mq[ca].pop_front());
         if (hb) void'(mq[cb].pop_front());
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R10: empty after reset, ready on every channel, no stall
      for (int c = 0; c < 7; c++) cyc("R10", 1'b0, 3'(c), 0, 1'b1, 5'd0, 5'd1);
      // R1 R2: words land in channel 0 and show through register 2
      cyc("R1", 1'b1, 3'd0, 32'hA000_0001, 1'b0, 5'd0, 5'd0);
      cyc("R1", 1'b1, 3'd0, 32'hA000_0002, 1'b0, 5'd0, 5'd0);
      // R3: destructive reads return successive words
      cyc("R3", 1'b0, 3'd0, 0, 1'b1, 5'd2, 5'd0);
      cyc("R3", 1'b0, 3'd0, 0, 1'b1, 5'd2, 5'd0);
      cyc("R3", 1'b0, 3'd0, 0, 1'b1, 5'd2, 5'd0);   // now empty: stalls
      // R4: read of empty channel 2 with a same-cycle write stalls, then issues
      cyc("R4", 1'b1, 3'd2, 32'hB000_0001, 1'b1, 5'd0, 5'd4);
      cyc("R4", 1'b0, 3'd2, 0, 1'b1, 5'd0, 5'd4);
      cyc("R4", 1'b0, 3'd2, 0, 1'b1, 5'd4, 5'd1);
      // R5: fill channel 1, fifth write held off, no channel 7
      for (int i = 0; i < 5; i++) cyc("R5", 1'b1, 3'd1, 32'hC000_0000 + i, 1'b0, 5'd0, 5'd0);
      cyc("R5", 1'b1, 3'd7, 32'hDEAD_0000, 1'b0, 5'd0, 5'd0);
      // R8: pop one, then write and read channel 1 together, then drain in order
      cyc("R8", 1'b0, 3'd1, 0, 1'b1, 5'd3, 5'd0);
      cyc("R8", 1'b1, 3'd1, 32'hC000_00FF, 1'b1, 5'd0, 5'd3);
      for (int i = 0; i < 4; i++) cyc("R8", 1'b0, 3'd1, 0, 1'b1, 5'd3, 5'd1);
      // R6: same-channel pair needs two words
      cyc("R6", 1'b1, 3'd3, 32'hE000_0001, 1'b0, 5'd0, 5'd0);
      cyc("R6", 1'b0, 3'd3, 0, 1'b1, 5'd5, 5'd5);
      cyc("R6", 1'b1, 3'd3, 32'hE000_0002, 1'b0, 5'd0, 5'd0);
      cyc("R6", 1'b0, 3'd3, 0, 1'b1, 5'd5, 5'd5);
      cyc("R6", 1'b0, 3'd3, 0, 1'b1, 5'd5, 5'd0);
      // R7: numbers outside the window pass the register file through
      cyc("R7", 1'b0, 3'd0, 0, 1'b1, 5'd1, 5'd8);
      cyc("R7", 1'b0, 3'd0, 0, 1'b1, 5'd31, 5'd0);
      // R9: channel 6 fills, holds off, and register 8 is not mapped to it
      for (int i = 0; i < 5; i++) cyc("R9", 1'b1, 3'd6, 32'hF000_0000 + i, 1'b1, 5'd8, 5'd9);
      // R3: random traffic against the model
      for (int i = 0; i < 4000; i++)
         cyc("R3", 1'($urandom), 3'($urandom), $urandom, 1'($urandom),
             5'($urandom % 10), 5'($urandom % 10));
      finish_run();
   end
endmodule